// File: doc/BRIEF.md
# Banked CPU Register File with Status-Word Bank Selection

This block is the general-purpose register store of a small 8/16-bit processor. It holds thirty-two byte cells arranged as four banks of eight registers. It also holds the processor status word, whose two bank-select bits pick which bank the register ports address. There are ports for single byte registers and for register pairs. A direct window port reaches every one of the thirty-two cells whatever bank is active.

A 16-bit stack pointer lives beside the banks and is always kept even. A branch-condition evaluator turns the zero and carry flags of the status word, or an operand value, into a single taken/not-taken bit. The surrounding datapath drives the read selectors combinationally and issues writes that take effect at the next rising clock edge.

Top module: `regbank_file`

## Requirements
- R1: After reset every one of the 32 cells reads 0x11, the status word reads 0x06 and the stack pointer reads 0x0000.
- R2: Byte register codes within a bank are X=0, A=1, C=2, B=3, E=4, D=5, L=6, H=7. A byte write to a code is returned by a byte read of the same code in the same bank from the next cycle on.
- R3: A byte read selector with bit 3 set (the "none" register) returns 0x00 whatever the cells hold.
- R4: The active bank is 2·psw[5] + psw[3]. Register code k of bank b is window cell (3 − b)·8 + k, so bank 0 occupies cells 24 to 31.
- R5: Pair codes are AX=0, BC=1, DE=2, HL=3. A pair read returns {high, low} = {A,X}, {B,C}, {D,E} or {H,L}. A pair write stores bits 15:8 in the high register and bits 7:0 in the low register.
- R6: When writes in one cycle hit the same cell, the pair write beats the byte write, and both beat the window write. Writes to different cells in one cycle all take effect.
- R7: The window port reads and writes any of the 32 cells by address 0 to 31, independent of the active bank.
- R8: The status word loads on a write and the new bank is used only from the following cycle. In the write cycle itself, reads still use the old bank. Bit layout from bit 7 down: IE, Z, bank-select high, AC, bank-select low, ISP1, ISP0, CY.
- R9: A stack pointer write stores the value with bit 0 cleared. The misalignment flag is high in exactly the cycles where a write with bit 0 set is presented.
- R10: Condition codes are T=0 (operand nonzero), F=1 (operand zero), C=2 (CY), NC=3 (not CY), Z=4 (Z), NZ=5 (not Z), H=6 (neither Z nor CY), NH=7 (Z or CY). CY is psw[0] and Z is psw[6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_byte_sel | input | 4 | Byte read code; bit 3 selects the "none" register |
| rd_byte_data | output | 8 | Byte read result from the active bank |
| rd_pair_sel | input | 2 | Pair read code |
| rd_pair_data | output | 16 | Pair read result, high register in bits 15:8 |
| wr_byte_en | input | 1 | Byte write enable |
| wr_byte_sel | input | 3 | Byte write code |
| wr_byte_data | input | 8 | Byte write value |
| wr_pair_en | input | 1 | Pair write enable |
| wr_pair_sel | input | 2 | Pair write code |
| wr_pair_data | input | 16 | Pair write value |
| win_addr | input | 5 | Window cell address for read and write |
| win_wr_en | input | 1 | Window write enable |
| win_wr_data | input | 8 | Window write value |
| win_rd_data | output | 8 | Window read result |
| psw_wr_en | input | 1 | Status word write enable |
| psw_wr_data | input | 8 | Status word write value |
| psw_q | output | 8 | Current status word |
| sp_wr_en | input | 1 | Stack pointer write enable |
| sp_wr_data | input | 16 | Stack pointer write value |
| sp_q | output | 16 | Current stack pointer, always even |
| sp_misalign | output | 1 | An odd stack pointer value is being written this cycle |
| cond_sel | input | 3 | Branch condition code |
| cond_operand | input | 16 | Operand tested by the T and F conditions |
| cond_true | output | 1 | Condition result |

## Verification
The assertions assume that the enables are never unknown once reset is released and that the window address stays within 0 to 31. Under those assumptions each enabled write must land in the cell that the active bank maps it to, unless a write of higher priority covers that cell. The window-against-byte-port check assumes the two read selectors settle in the same cycle. The bench drives every input away from the clock edge and releases every enable after one cycle. Same-cell collisions are arranged on purpose in a single cycle only to exercise the priority rule.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

   // status word bit positions (bank selection is decoded from RB1/RB0)
   localparam int PSW_CY   = 0;
   localparam int PSW_ISP0 = 1;
   localparam int PSW_ISP1 = 2;
   localparam int PSW_RB0  = 3;
   localparam int PSW_AC   = 4;
   localparam int PSW_RB1  = 5;
   localparam int PSW_Z    = 6;
   localparam int PSW_IE   = 7;
   localparam int PSW_W    = 8;

   typedef enum logic [2:0] {
      COND_T  = 3'd0,
      COND_F  = 3'd1,
      COND_C  = 3'd2,
      COND_NC = 3'd3,
      COND_Z  = 3'd4,
      COND_NZ = 3'd5,
      COND_H  = 3'd6,
      COND_NH = 3'd7
   } cond_e;

   function automatic logic [1:0] bank_of(input logic [PSW_W-1:0] psw);
      return {psw[PSW_RB1], psw[PSW_RB0]};
   endfunction

endpackage

// File: rtl/regbank_storage.sv
module regbank_storage #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 32,
   parameter logic [DATA_W-1:0] FILL = 8'h11,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pair_we,
   input  logic [AW-1:0]     pair_lo_idx,
   input  logic [2*DATA_W-1:0] pair_d,
   input  logic              byte_we,
   input  logic [AW-1:0]     byte_idx,
   input  logic [DATA_W-1:0] byte_d,
   input  logic              win_we,
   input  logic [AW-1:0]     win_idx,
   input  logic [DATA_W-1:0] win_d,
   input  logic [AW-1:0]     rd_byte_idx,
   output logic [DATA_W-1:0] rd_byte_q,
   input  logic [AW-1:0]     rd_pair_lo_idx,
   output logic [2*DATA_W-1:0] rd_pair_q,
   output logic [DATA_W-1:0] rd_win_q
);

   localparam logic [AW-1:0] ONE = AW'(1);

   logic [DEPTH-1:0][DATA_W-1:0] cells;
   logic [AW-1:0] pair_hi_idx;
   logic [AW-1:0] rd_pair_hi_idx;

   assign pair_hi_idx    = pair_lo_idx | ONE;
   assign rd_pair_hi_idx = rd_pair_lo_idx | ONE;

   if (DEPTH != (1 << AW)) begin : g_depth_bad
      $error("regbank_storage: DEPTH must be a power of two");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam logic [AW-1:0] IDX = AW'(i);
      localparam bit IS_HI = (i % 2) == 1;
      logic [DATA_W-1:0] q;
      logic pair_hit;
      logic [DATA_W-1:0] pair_part;

      if (IS_HI) begin : g_hi
         assign pair_hit  = pair_we && (pair_hi_idx == IDX);
         assign pair_part = pair_d[2*DATA_W-1:DATA_W];
      end else begin : g_lo
         assign pair_hit  = pair_we && (pair_lo_idx == IDX);
         assign pair_part = pair_d[DATA_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= FILL;
         end else if (pair_hit) begin
            q <= pair_part;
         end else if (byte_we && (byte_idx == IDX)) begin
            q <= byte_d;
         end else if (win_we && (win_idx == IDX)) begin
            q <= win_d;
         end
      end

      assign cells[i] = q;
   end

   assign rd_byte_q = cells[rd_byte_idx];
   assign rd_pair_q = {cells[rd_pair_hi_idx], cells[rd_pair_lo_idx]};
   assign rd_win_q  = cells[win_idx];

   // R5
   pair_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_we |=> (cells[$past(pair_lo_idx) | ONE] == $past(pair_d[2*DATA_W-1:DATA_W]))
               && (cells[$past(pair_lo_idx) & ~ONE] == $past(pair_d[DATA_W-1:0])));

   // R6
   byte_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_we && !(pair_we && ((pair_lo_idx | ONE) == (byte_idx | ONE))))
      |=> cells[$past(byte_idx)] == $past(byte_d));

   // R7
   win_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_we && !(pair_we && ((pair_lo_idx | ONE) == (win_idx | ONE)))
              && !(byte_we && (byte_idx == win_idx)))
      |=> cells[$past(win_idx)] == $past(win_d));

endmodule

// File: rtl/regbank_status.sv
module regbank_status #(
   parameter int PSW_W = 8,
   parameter logic [PSW_W-1:0] PSW_INIT = 8'h06,
   parameter int SP_W = 16,
   parameter logic [SP_W-1:0] SP_INIT = 16'h0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             psw_wr_en,
   input  logic [PSW_W-1:0] psw_wr_data,
   output logic [PSW_W-1:0] psw_q,
   input  logic             sp_wr_en,
   input  logic [SP_W-1:0]  sp_wr_data,
   output logic [SP_W-1:0]  sp_q,
   output logic             sp_misalign
);

   if (SP_INIT[0] != 1'b0) begin : g_sp_init_bad
      $error("regbank_status: SP_INIT must be even");
   end

   logic [PSW_W-1:0] psw_r;
   logic [SP_W-1:0]  sp_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psw_r <= PSW_INIT;
      end else if (psw_wr_en) begin
         psw_r <= psw_wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_r <= SP_INIT;
      end else if (sp_wr_en) begin
         sp_r <= {sp_wr_data[SP_W-1:1], 1'b0};
      end
   end

   assign psw_q       = psw_r;
   assign sp_q        = sp_r;
   assign sp_misalign = sp_wr_en & sp_wr_data[0];

   // R8
   psw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psw_wr_en |=> psw_q == $past(psw_wr_data));

   // R8
   psw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !psw_wr_en |=> $stable(psw_q));

   // R9
   sp_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sp_wr_en |=> sp_q == {$past(sp_wr_data[SP_W-1:1]), 1'b0});

   // R9
   sp_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sp_q[0] == 1'b0);

endmodule

// File: rtl/regbank_cond.sv
module regbank_cond
   import regbank_pkg::*;
#(
   parameter int OPND_W = 16
) (
   input  logic [2:0]        cond_sel,
   input  logic              flag_z,
   input  logic              flag_cy,
   input  logic [OPND_W-1:0] operand,
   output logic              cond_true
);

   logic opnd_nz;
   assign opnd_nz = |operand;

   always_comb begin
      unique case (cond_e'(cond_sel))
         COND_T:  cond_true = opnd_nz;
         COND_F:  cond_true = ~opnd_nz;
         COND_C:  cond_true = flag_cy;
         COND_NC: cond_true = ~flag_cy;
         COND_Z:  cond_true = flag_z;
         COND_NZ: cond_true = ~flag_z;
         COND_H:  cond_true = ~(flag_z | flag_cy);
         COND_NH: cond_true = flag_z | flag_cy;
         default: cond_true = 1'b0;
      endcase
   end

endmodule

// File: rtl/regbank_file.sv
module regbank_file
   import regbank_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int REGS_PER_BANK = 8,
   parameter int NUM_BANKS     = 4,
   parameter int SP_W          = 16,
   parameter int OPND_W        = 16,
   parameter logic [DATA_W-1:0] CELL_INIT = 8'h11,
   parameter logic [7:0]        PSW_INIT  = 8'h06,
   parameter logic [SP_W-1:0]   SP_INIT   = '0,
   localparam int REG_AW   = $clog2(REGS_PER_BANK),
   localparam int BANK_AW  = $clog2(NUM_BANKS),
   localparam int PAIR_AW  = REG_AW - 1,
   localparam int WIN_CELLS = NUM_BANKS * REGS_PER_BANK,
   localparam int WIN_AW   = REG_AW + BANK_AW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [REG_AW:0]     rd_byte_sel,
   output logic [DATA_W-1:0]   rd_byte_data,
   input  logic [PAIR_AW-1:0]  rd_pair_sel,
   output logic [2*DATA_W-1:0] rd_pair_data,
   input  logic                wr_byte_en,
   input  logic [REG_AW-1:0]   wr_byte_sel,
   input  logic [DATA_W-1:0]   wr_byte_data,
   input  logic                wr_pair_en,
   input  logic [PAIR_AW-1:0]  wr_pair_sel,
   input  logic [2*DATA_W-1:0] wr_pair_data,
   input  logic [WIN_AW-1:0]   win_addr,
   input  logic                win_wr_en,
   input  logic [DATA_W-1:0]   win_wr_data,
   output logic [DATA_W-1:0]   win_rd_data,
   input  logic                psw_wr_en,
   input  logic [7:0]          psw_wr_data,
   output logic [7:0]          psw_q,
   input  logic                sp_wr_en,
   input  logic [SP_W-1:0]     sp_wr_data,
   output logic [SP_W-1:0]     sp_q,
   output logic                sp_misalign,
   input  logic [2:0]          cond_sel,
   input  logic [OPND_W-1:0]   cond_operand,
   output logic                cond_true
);

   if (NUM_BANKS != 4) begin : g_banks_bad
      $error("regbank_file: two status bits select exactly four banks");
   end
   if (REGS_PER_BANK < 2 || REGS_PER_BANK != (1 << REG_AW)) begin : g_regs_bad
      $error("regbank_file: REGS_PER_BANK must be a power of two, at least 2");
   end
   if (DATA_W != PSW_W) begin : g_width_bad
      $error("regbank_file: cell width must match the status word");
   end

   // active bank and its window base: bank b lives at (NUM_BANKS-1-b)
   logic [BANK_AW-1:0] bank;
   logic [BANK_AW-1:0] base;
   assign bank = bank_of(psw_q);
   assign base = ~bank;

   logic [WIN_AW-1:0] rd_byte_idx, rd_pair_idx, wr_byte_idx, wr_pair_idx;
   assign rd_byte_idx = {base, rd_byte_sel[REG_AW-1:0]};
   assign rd_pair_idx = {base, rd_pair_sel, 1'b0};
   assign wr_byte_idx = {base, wr_byte_sel};
   assign wr_pair_idx = {base, wr_pair_sel, 1'b0};

   logic [DATA_W-1:0] byte_q;

   regbank_storage #(
      .DATA_W (DATA_W),
      .DEPTH  (WIN_CELLS),
      .FILL   (CELL_INIT)
   ) u_storage (
      .clk            (clk),
      .rst_n          (rst_n),
      .pair_we        (wr_pair_en),
      .pair_lo_idx    (wr_pair_idx),
      .pair_d         (wr_pair_data),
      .byte_we        (wr_byte_en),
      .byte_idx       (wr_byte_idx),
      .byte_d         (wr_byte_data),
      .win_we         (win_wr_en),
      .win_idx        (win_addr),
      .win_d          (win_wr_data),
      .rd_byte_idx    (rd_byte_idx),
      .rd_byte_q      (byte_q),
      .rd_pair_lo_idx (rd_pair_idx),
      .rd_pair_q      (rd_pair_data),
      .rd_win_q       (win_rd_data)
   );

   // "none" register reads as zero
   assign rd_byte_data = rd_byte_sel[REG_AW] ? '0 : byte_q;

   regbank_status #(
      .PSW_W    (PSW_W),
      .PSW_INIT (PSW_INIT),
      .SP_W     (SP_W),
      .SP_INIT  (SP_INIT)
   ) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .psw_wr_en   (psw_wr_en),
      .psw_wr_data (psw_wr_data),
      .psw_q       (psw_q),
      .sp_wr_en    (sp_wr_en),
      .sp_wr_data  (sp_wr_data),
      .sp_q        (sp_q),
      .sp_misalign (sp_misalign)
   );

   regbank_cond #(
      .OPND_W (OPND_W)
   ) u_cond (
      .cond_sel  (cond_sel),
      .flag_z    (psw_q[PSW_Z]),
      .flag_cy   (psw_q[PSW_CY]),
      .operand   (cond_operand),
      .cond_true (cond_true)
   );

   // R4
   bank_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_byte_sel[REG_AW] && win_addr == {~bank_of(psw_q), rd_byte_sel[REG_AW-1:0]})
      |-> rd_byte_data == win_rd_data);

   // R3
   none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_byte_sel[REG_AW] |-> rd_byte_data == '0);

   // R8
   bank_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psw_wr_en && !wr_byte_en && !wr_pair_en && !win_wr_en)
      |=> rd_pair_data == {u_storage.cells[{~bank_of(psw_q), rd_pair_sel, 1'b1}],
                           u_storage.cells[{~bank_of(psw_q), rd_pair_sel, 1'b0}]});

endmodule

// File: tb/regbank_file_bench.sv
module regbank_file_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rd_byte_sel = '0;
   logic [7:0]  rd_byte_data;
   logic [1:0]  rd_pair_sel = '0;
   logic [15:0] rd_pair_data;
   logic        wr_byte_en = 1'b0;
   logic [2:0]  wr_byte_sel = '0;
   logic [7:0]  wr_byte_data = '0;
   logic        wr_pair_en = 1'b0;
   logic [1:0]  wr_pair_sel = '0;
   logic [15:0] wr_pair_data = '0;
   logic [4:0]  win_addr = '0;
   logic        win_wr_en = 1'b0;
   logic [7:0]  win_wr_data = '0;
   logic [7:0]  win_rd_data;
   logic        psw_wr_en = 1'b0;
   logic [7:0]  psw_wr_data = '0;
   logic [7:0]  psw_q;
   logic        sp_wr_en = 1'b0;
   logic [15:0] sp_wr_data = '0;
   logic [15:0] sp_q;
   logic        sp_misalign;
   logic [2:0]  cond_sel = '0;
   logic [15:0] cond_operand = '0;
   logic        cond_true;

   always #(CLK_PERIOD/2) clk = ~clk;

   regbank_file u_regbank_file (.*);

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [7:0] exp_mem [32];
   logic [7:0] exp_psw;

   function automatic int cell_of(input int b, input int code);
      return (3 - b) * 8 + code;
   endfunction

   function automatic int cur_bank();
      return 2 * exp_psw[5] + exp_psw[3];
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_psw(input logic [7:0] v);
      psw_wr_en = 1'b1; psw_wr_data = v;
      tick();
      psw_wr_en = 1'b0;
      exp_psw = v;
      #1;
   endtask

   task automatic put_byte(input int code, input logic [7:0] v);
      wr_byte_en = 1'b1; wr_byte_sel = 3'(code); wr_byte_data = v;
      tick();
      wr_byte_en = 1'b0;
      exp_mem[cell_of(cur_bank(), code)] = v;
      #1;
   endtask

   task automatic t_reset();
      for (int a = 0; a < 32; a++) begin
         win_addr = 5'(a); #1;
         chk($sformatf("R1 reset cell %0d", a), win_rd_data, 8'h11);
      end
      chk("R1 reset psw", psw_q, 8'h06);
      chk("R1 reset sp", sp_q, 16'h0000);
      rd_pair_sel = 2'd0; #1;
      chk("R1 reset pair AX", rd_pair_data, 16'h1111);
      for (int a = 0; a < 32; a++) exp_mem[a] = 8'h11;
      exp_psw = 8'h06;
   endtask

   task automatic t_bank_map();
      for (int b = 0; b < 4; b++) begin
         set_psw(8'h06 | (b[1] ? 8'h20 : 8'h00) | (b[0] ? 8'h08 : 8'h00));
         for (int k = 0; k < 8; k++) put_byte(k, 8'((b << 4) | k));
      end
      for (int b = 0; b < 4; b++) begin
         for (int k = 0; k < 8; k++) begin
            win_addr = 5'(cell_of(b, k)); #1;
            chk($sformatf("R4 bank %0d code %0d window", b, k), win_rd_data, 8'((b << 4) | k));
         end
      end
      set_psw(8'h06 | 8'h20);
      for (int k = 0; k < 8; k++) begin
         rd_byte_sel = 4'(k); #1;
         chk($sformatf("R2 bank2 byte read code %0d", k), rd_byte_data, 8'(8'h20 | k));
      end
      for (int p = 0; p < 4; p++) begin
         rd_pair_sel = 2'(p); #1;
         chk($sformatf("R5 bank2 pair read %0d", p), rd_pair_data,
             {8'(8'h20 | (2*p+1)), 8'(8'h20 | (2*p))});
      end
   endtask

   task automatic t_none();
      rd_byte_sel = 4'h8; #1;
      chk("R3 none register", rd_byte_data, 8'h00);
      rd_byte_sel = 4'hF; #1;
      chk("R3 none register code 15", rd_byte_data, 8'h00);
   endtask

   task automatic t_pair_write();
      wr_pair_en = 1'b1; wr_pair_sel = 2'd0; wr_pair_data = 16'h1234;
      tick();
      wr_pair_en = 1'b0; #1;
      rd_byte_sel = 4'd1; #1;
      chk("R5 AX write high A", rd_byte_data, 8'h12);
      rd_byte_sel = 4'd0; #1;
      chk("R5 AX write low X", rd_byte_data, 8'h34);
      rd_pair_sel = 2'd0; #1;
      chk("R5 AX pair read", rd_pair_data, 16'h1234);
      exp_mem[cell_of(cur_bank(), 1)] = 8'h12;
      exp_mem[cell_of(cur_bank(), 0)] = 8'h34;
   endtask

   task automatic t_priority();
      int b;
      b = cur_bank();
      wr_pair_en = 1'b1; wr_pair_sel = 2'd1; wr_pair_data = 16'hABCD;
      wr_byte_en = 1'b1; wr_byte_sel = 3'd2; wr_byte_data = 8'h55;
      win_wr_en = 1'b1; win_addr = 5'(cell_of(b, 2)); win_wr_data = 8'h77;
      tick();
      wr_pair_en = 1'b0; wr_byte_en = 1'b0; win_wr_en = 1'b0; #1;
      rd_byte_sel = 4'd2; #1;
      chk("R6 pair beats byte and window on C", rd_byte_data, 8'hCD);
      rd_byte_sel = 4'd3; #1;
      chk("R6 pair high B", rd_byte_data, 8'hAB);
      wr_byte_en = 1'b1; wr_byte_sel = 3'd5; wr_byte_data = 8'h66;
      win_wr_en = 1'b1; win_addr = 5'(cell_of(b, 5)); win_wr_data = 8'h99;
      tick();
      wr_byte_en = 1'b0; win_wr_en = 1'b0; #1;
      rd_byte_sel = 4'd5; #1;
      chk("R6 byte beats window on D", rd_byte_data, 8'h66);
      wr_byte_en = 1'b1; wr_byte_sel = 3'd6; wr_byte_data = 8'h3C;
      win_wr_en = 1'b1; win_addr = 5'(cell_of(b, 7)); win_wr_data = 8'hC3;
      tick();
      wr_byte_en = 1'b0; win_wr_en = 1'b0; #1;
      rd_pair_sel = 2'd3; #1;
      chk("R6 disjoint byte and window both land", rd_pair_data, 16'hC33C);
   endtask

   task automatic t_window();
      win_wr_en = 1'b1; win_addr = 5'(cell_of(1, 7)); win_wr_data = 8'h5A;
      tick();
      win_wr_en = 1'b0; #1;
      chk("R7 window write inactive bank", win_rd_data, 8'h5A);
      set_psw(8'h0E);
      rd_byte_sel = 4'd7; #1;
      chk("R7 window cell seen via bank1 H", rd_byte_data, 8'h5A);
      win_addr = 5'd31; #1;
      chk("R7 window reads bank0 H", win_rd_data, 8'h07);
   endtask

   task automatic t_psw_delay();
      rd_byte_sel = 4'd4;
      psw_wr_en = 1'b1; psw_wr_data = 8'hE6;
      #1;
      chk("R8 old bank during write cycle", rd_byte_data, 8'h14);
      tick();
      psw_wr_en = 1'b0; exp_psw = 8'hE6; #1;
      chk("R8 psw loaded", psw_q, 8'hE6);
      chk("R8 new bank after edge", rd_byte_data, 8'h24);
   endtask

   task automatic t_sp();
      sp_wr_en = 1'b1; sp_wr_data = 16'h1235; #1;
      chk("R9 misalign flag on odd write", sp_misalign, 1'b1);
      tick();
      sp_wr_en = 1'b0; #1;
      chk("R9 odd value stored even", sp_q, 16'h1234);
      chk("R9 flag clears", sp_misalign, 1'b0);
      sp_wr_en = 1'b1; sp_wr_data = 16'hFFFE; #1;
      chk("R9 no flag on even write", sp_misalign, 1'b0);
      tick();
      sp_wr_en = 1'b0; #1;
      chk("R9 even value stored", sp_q, 16'hFFFE);
   endtask

   task automatic t_cond();
      for (int zc = 0; zc < 4; zc++) begin
         logic z, cy;
         z = zc[1]; cy = zc[0];
         set_psw(8'h06 | (z ? 8'h40 : 8'h00) | (cy ? 8'h01 : 8'h00));
         for (int c = 2; c < 8; c++) begin
            logic e;
            case (c)
               2: e = cy;
               3: e = !cy;
               4: e = z;
               5: e = !z;
               6: e = !(z || cy);
               default: e = z || cy;
            endcase
            cond_sel = 3'(c); #1;
            chk($sformatf("R10 cond %0d z=%0d cy=%0d", c, z, cy), cond_true, e);
         end
      end
      cond_operand = 16'h0000; cond_sel = 3'd0; #1;
      chk("R10 T on zero", cond_true, 1'b0);
      cond_sel = 3'd1; #1;
      chk("R10 F on zero", cond_true, 1'b1);
      cond_operand = 16'h0100; cond_sel = 3'd0; #1;
      chk("R10 T on upper nonzero", cond_true, 1'b1);
      cond_sel = 3'd1; #1;
      chk("R10 F on nonzero", cond_true, 1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 2 + 3);
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_bank_map();
      t_none();
      t_pair_write();
      t_priority();
      set_psw(8'h06 | 8'h08);
      t_psw_delay_prep();
      t_window();
      t_sp();
      t_cond();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // bank1 code 4 holds 0x14 and bank2 code 4 holds 0x24 from t_bank_map
   task automatic t_psw_delay_prep();
      t_psw_delay();
   endtask

endmodule